// File: doc/BRIEF.md
# Linked Channel Pair Controller

This block runs transfer channels as linked pairs. Each pair has an even channel (A) and an odd channel (B), and the two take turns serving the pair's requests. Each channel owns one block of transfers. When the serving channel finishes its block, service passes to the other channel. While one channel moves data, software can reload the pointers and count of the idle channel, which gives double or multi-buffered transfers with no gap between blocks.

For each pair the block takes:
- the two channels' link bits and their current counts;
- a request strobe;
- a transfer-done pulse, which decrements the serving channel's count.

For each pair it drives:
- a select that shows which channel serves;
- a transfer-grant;
- a sticky link-event flag.

The flags of all pairs are masked by per-pair enable bits. They are then ORed into one shared link interrupt request. The count registers themselves are outside this block. It only sees their values.

Top module: `lcp_link_ctrl`

## Requirements
- R1: Pair p groups channel 2p (even, A) with channel 2p+1 (odd, B). Channel c's link bit is `link_bits[c]`. Channel c's count is `cnt_flat[c*CNT_W +: CNT_W]`. Every pair's logic reads only its own channels' bits and counts.
- R2: Link mode is on for a pair when either of its two link bits is 1. While it is off, `xfer_grant[p]` is 0. The cycle after a clock edge at which link mode was off, `sel_odd[p]` is 0 and the pair is not stalled.
- R3: After reset, and after link mode has been off, the first transfer uses the even channel (`sel_odd[p]` = 0).
- R4: `xfer_grant[p]` is 1 in the same cycle as `xfer_req[p]` when all three of these hold: link mode is on, the pair is not stalled, and the serving channel's count is nonzero.
- R5: A `xfer_done[p]` pulse while the serving channel's count is 1 is a handover event. If the partner's link bit is 1 and the partner's count is nonzero, `sel_odd[p]` toggles in the next cycle.
- R6: If the partner is not eligible at a handover, the pair stalls. While stalled it grants nothing. As soon as the partner's link bit is 1 and its count is nonzero, service moves to the partner in the next cycle and the stall ends.
- R7: A serving count of all ones means continuous transfers. A done pulse then causes neither a switch nor a flag.
- R8: A handover sets `link_flag[p]` in the next cycle, and the flag stays set until a `flag_clr[p]` pulse. If a handover and a clear arrive in the same cycle, the flag stays set.
- R9: `link_irq` is 1 exactly when, for at least one pair, both `link_flag[p]` and `irq_en[p]` are 1. It follows the flags with no added delay.
- R10: A done pulse while the serving count is neither 1 nor all ones leaves the select and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_bits | input | 2*NUM_PAIRS | Per-channel link bit |
| cnt_flat | input | 2*NUM_PAIRS*CNT_W | Per-channel current count, channel c at c*CNT_W |
| xfer_req | input | NUM_PAIRS | Per-pair request strobe |
| xfer_done | input | NUM_PAIRS | Per-pair transfer-done (decrement) pulse |
| flag_clr | input | NUM_PAIRS | Software clear of the link flags |
| irq_en | input | NUM_PAIRS | Per-pair interrupt enable |
| sel_odd | output | NUM_PAIRS | 1 when the odd channel serves the pair |
| xfer_grant | output | NUM_PAIRS | Transfer issued for the pair this cycle |
| link_flag | output | NUM_PAIRS | Sticky link event flag |
| link_irq | output | 1 | Shared, enable-masked link interrupt request |

## Verification
A corrupt select shows up one cycle after the edge that wrote it. The bench then sees `xfer_grant` follow the wrong channel's count, or sees a switch that should not have happened. A stall bit that is wrongly set shows at once as a missing grant while a request is present. A stall bit that is wrongly clear shows as a grant with no eligible partner. A lost or spurious flag reaches `link_flag` and `link_irq` in the cycle after the event. The bench checks the cycle right after each handover, stall, resume and clear. It also drives a pair other than the first, to catch index mix-ups.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

    typedef enum logic {
        SEL_EVEN = 1'b0,
        SEL_ODD  = 1'b1
    } chan_sel_e;

    typedef struct packed {
        chan_sel_e act;
        logic      stalled;
    } pair_state_t;

    typedef struct packed {
        logic grant;
        logic handover;
    } pair_evt_t;

    function automatic chan_sel_e other_chan(input chan_sel_e s);
        return (s == SEL_ODD) ? SEL_EVEN : SEL_ODD;
    endfunction

endpackage

// File: rtl/lcp_pair_fsm.sv
module lcp_pair_fsm
    import lcp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_a,
    input  logic             link_b,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             req,
    input  logic             done,
    output logic             sel_odd,
    output pair_evt_t        evt
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    pair_state_t      st_q, st_d;
    logic             link_on;
    logic             part_link;
    logic             part_ok;
    logic [CNT_W-1:0] act_cnt;
    logic [CNT_W-1:0] part_cnt;

    always_comb begin
        link_on   = link_a | link_b;
        act_cnt   = (st_q.act == SEL_ODD) ? cnt_b  : cnt_a;
        part_cnt  = (st_q.act == SEL_ODD) ? cnt_a  : cnt_b;
        part_link = (st_q.act == SEL_ODD) ? link_a : link_b;
        part_ok   = part_link && (part_cnt != '0);
    end

    always_comb begin
        evt.grant    = link_on && req && !st_q.stalled && (act_cnt != '0);
        evt.handover = link_on && done && !st_q.stalled && (act_cnt == CNT_LAST);
    end

    always_comb begin
        st_d = st_q;
        if (!link_on) begin
            st_d.act     = SEL_EVEN;
            st_d.stalled = 1'b0;
        end else if (st_q.stalled) begin
            if (part_ok) begin
                st_d.act     = other_chan(st_q.act);
                st_d.stalled = 1'b0;
            end
        end else if (evt.handover) begin
            if (part_ok) begin
                st_d.act = other_chan(st_q.act);
            end else begin
                st_d.stalled = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{act: SEL_EVEN, stalled: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_odd = (st_q.act == SEL_ODD);

endmodule

// File: rtl/lcp_flag_bank.sv
module lcp_flag_bank #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PAIRS-1:0] set_i,
    input  logic [NUM_PAIRS-1:0] clr_i,
    input  logic [NUM_PAIRS-1:0] en_i,
    output logic [NUM_PAIRS-1:0] flags_o,
    output logic                 irq_o
);

    logic [NUM_PAIRS-1:0] flags_q;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[p] <= 1'b0;
            end else if (set_i[p]) begin
                flags_q[p] <= 1'b1;
            end else if (clr_i[p]) begin
                flags_q[p] <= 1'b0;
            end
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);

endmodule

// File: rtl/lcp_link_ctrl.sv
module lcp_link_ctrl
    import lcp_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [2*NUM_PAIRS-1:0]         link_bits,
    input  logic [2*NUM_PAIRS*CNT_W-1:0]   cnt_flat,
    input  logic [NUM_PAIRS-1:0]           xfer_req,
    input  logic [NUM_PAIRS-1:0]           xfer_done,
    input  logic [NUM_PAIRS-1:0]           flag_clr,
    input  logic [NUM_PAIRS-1:0]           irq_en,
    output logic [NUM_PAIRS-1:0]           sel_odd,
    output logic [NUM_PAIRS-1:0]           xfer_grant,
    output logic [NUM_PAIRS-1:0]           link_flag,
    output logic                           link_irq
);

    localparam int NUM_CH = 2 * NUM_PAIRS;

    pair_evt_t            evt [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] handover;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int CH_A = 2 * p;
        localparam int CH_B = 2 * p + 1;

        lcp_pair_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk     (clk),
            .rst     (rst),
            .link_a  (link_bits[CH_A]),
            .link_b  (link_bits[CH_B]),
            .cnt_a   (cnt_flat[CH_A*CNT_W +: CNT_W]),
            .cnt_b   (cnt_flat[CH_B*CNT_W +: CNT_W]),
            .req     (xfer_req[p]),
            .done    (xfer_done[p]),
            .sel_odd (sel_odd[p]),
            .evt     (evt[p])
        );

        assign xfer_grant[p] = evt[p].grant;
        assign handover[p]   = evt[p].handover;
    end

    lcp_flag_bank #(.NUM_PAIRS(NUM_PAIRS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (handover),
        .clr_i   (flag_clr),
        .en_i    (irq_en),
        .flags_o (link_flag),
        .irq_o   (link_irq)
    );

    if (NUM_CH < 2) begin : g_bad_cfg
        initial $display("lcp_link_ctrl: NUM_PAIRS must be at least 1");
    end

endmodule

// File: rtl/lcp_link_ctrl_chk.sv
module lcp_link_ctrl_chk #(
    parameter int NUM_PAIRS = 4,
    parameter int CNT_W     = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic [2*NUM_PAIRS-1:0]       link_bits,
    input logic [2*NUM_PAIRS*CNT_W-1:0] cnt_flat,
    input logic [NUM_PAIRS-1:0]         xfer_req,
    input logic [NUM_PAIRS-1:0]         xfer_done,
    input logic [NUM_PAIRS-1:0]         flag_clr,
    input logic [NUM_PAIRS-1:0]         irq_en,
    input logic [NUM_PAIRS-1:0]         sel_odd,
    input logic [NUM_PAIRS-1:0]         xfer_grant,
    input logic [NUM_PAIRS-1:0]         link_flag,
    input logic                         link_irq
);

    AST_IRQ_WHEN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        ((link_flag & irq_en) != '0) |-> link_irq); // R9

    AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (rst)
        ((link_flag & irq_en) == '0) |-> !link_irq); // R9

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        logic             lnk_on;
        logic [CNT_W-1:0] act_cnt;
        assign lnk_on  = link_bits[2*p] | link_bits[2*p+1];
        assign act_cnt = sel_odd[p] ? cnt_flat[(2*p+1)*CNT_W +: CNT_W]
                                    : cnt_flat[(2*p)*CNT_W +: CNT_W];

        AST_OFF_GOES_EVEN: assert property (@(posedge clk) disable iff (rst)
            !lnk_on |=> !sel_odd[p]); // R2

        AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
            !lnk_on |-> !xfer_grant[p]); // R2

        AST_GRANT_NEEDS_COUNT: assert property (@(posedge clk) disable iff (rst)
            xfer_grant[p] |-> (act_cnt != '0) && xfer_req[p]); // R4

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (link_flag[p] && !flag_clr[p]) |=> link_flag[p]); // R8

        AST_CONT_NO_SWITCH: assert property (@(posedge clk) disable iff (rst)
            (lnk_on && xfer_done[p] && (act_cnt == '1)) |=> $stable(sel_odd[p])); // R7
    end

endmodule

bind lcp_link_ctrl lcp_link_ctrl_chk #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/lcp_link_ctrl_bench.sv
module lcp_link_ctrl_bench;

    localparam int NP = 4;
    localparam int CW = 8;
    localparam int NSTEP = 17;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2*NP-1:0]      link_bits = '0;
    logic [2*NP*CW-1:0]   cnt_flat = '0;
    logic [NP-1:0]        xfer_req = '0, xfer_done = '0, flag_clr = '0, irq_en = '0;
    logic [NP-1:0]        sel_odd, xfer_grant, link_flag;
    logic                 link_irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lcp_link_ctrl #(.NUM_PAIRS(NP), .CNT_W(CW)) u_lcp_link_ctrl (.*);

    // entry: {link[1:0], cntA, cntB, req, done, clr, en, exp_sel, exp_grant, exp_flag, exp_irq}
    localparam logic [25:0] TBL [NSTEP] = '{
        {2'b01, 8'd3,   8'd2, 4'b1001, 4'b0100},
        {2'b11, 8'd3,   8'd2, 4'b1101, 4'b0100},
        {2'b11, 8'd2,   8'd2, 4'b1101, 4'b0100},
        {2'b11, 8'd1,   8'd2, 4'b1101, 4'b0100},
        {2'b11, 8'd1,   8'd2, 4'b1001, 4'b1111},
        {2'b11, 8'd1,   8'd2, 4'b0011, 4'b1011},
        {2'b11, 8'd0,   8'd1, 4'b1101, 4'b1100},
        {2'b11, 8'd0,   8'd0, 4'b1001, 4'b1011},
        {2'b11, 8'd4,   8'd0, 4'b1011, 4'b1011},
        {2'b11, 8'd4,   8'd0, 4'b1000, 4'b0100},
        {2'b11, 8'd255, 8'd0, 4'b1100, 4'b0100},
        {2'b11, 8'd255, 8'd0, 4'b1100, 4'b0100},
        {2'b01, 8'd1,   8'd5, 4'b1101, 4'b0100},
        {2'b01, 8'd0,   8'd5, 4'b1001, 4'b0011},
        {2'b00, 8'd0,   8'd5, 4'b1001, 4'b0011},
        {2'b01, 8'd2,   8'd5, 4'b1011, 4'b0111},
        {2'b01, 8'd2,   8'd5, 4'b0001, 4'b0000}
    };

    string tags [NSTEP] = '{"R3", "R10", "R10", "R5", "R5 R8 R9", "R8", "R5",
                            "R6", "R6", "R6 R8", "R7", "R7", "R6", "R6",
                            "R2", "R3", "R8"};

    task automatic check(input string req, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic drive_pair(input int p, input logic [1:0] lnk, input logic [CW-1:0] ca,
                              input logic [CW-1:0] cb, input logic rq, input logic dn,
                              input logic cl, input logic en);
        link_bits[2*p +: 2]        = lnk;
        cnt_flat[(2*p)*CW +: CW]   = ca;
        cnt_flat[(2*p+1)*CW +: CW] = cb;
        xfer_req[p]  = rq;
        xfer_done[p] = dn;
        flag_clr[p]  = cl;
        irq_en[p]    = en;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3", "reset sel", 32'(sel_odd), 0);
        check("R8", "reset flags", 32'(link_flag), 0);
        check("R9", "reset irq", 32'(link_irq), 0);

        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            drive_pair(0, TBL[i][25:24], TBL[i][23:16], TBL[i][15:8],
                       TBL[i][7], TBL[i][6], TBL[i][5], TBL[i][4]);
            #1;
            check(tags[i], $sformatf("step %0d sel", i),   32'(sel_odd[0]),    32'(TBL[i][3]));
            check(tags[i], $sformatf("step %0d grant", i), 32'(xfer_grant[0]), 32'(TBL[i][2]));
            check(tags[i], $sformatf("step %0d flag", i),  32'(link_flag[0]),  32'(TBL[i][1]));
            check(tags[i], $sformatf("step %0d irq", i),   32'(link_irq),      32'(TBL[i][0]));
        end

        // R8: handover into B, then handover back while clearing: set wins
        @(negedge clk); drive_pair(0, 2'b11, 8'd1, 8'd2, 1'b0, 1'b1, 1'b0, 1'b1);
        @(negedge clk); drive_pair(0, 2'b11, 8'd3, 8'd1, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); drive_pair(0, 2'b11, 8'd3, 8'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        check("R8", "set beats clear", 32'(link_flag[0]), 1);
        check("R5", "switched back to even", 32'(sel_odd[0]), 0);

        // R2: link off while odd serves returns to even
        drive_pair(0, 2'b11, 8'd1, 8'd2, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); drive_pair(0, 2'b11, 8'd3, 8'd2, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        check("R5", "odd serving before off", 32'(sel_odd[0]), 1);
        @(negedge clk); drive_pair(0, 2'b00, 8'd3, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); drive_pair(0, 2'b00, 8'd3, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check("R2", "off returns even", 32'(sel_odd[0]), 0);
        check("R9", "irq clear after flag clear", 32'(link_irq), 0);

        // R1: pair 3, link mode via its odd bit only
        drive_pair(3, 2'b10, 8'd1, 8'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        #1;
        check("R1", "pair3 grant", 32'(xfer_grant), 32'(4'b1000));
        @(negedge clk); drive_pair(3, 2'b10, 8'd0, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1);
        #1;
        check("R1", "pair3 sel", 32'(sel_odd), 32'(4'b1000));
        check("R1", "pair3 flag", 32'(link_flag), 32'(4'b1000));
        check("R9", "pair3 irq", 32'(link_irq), 1);
        irq_en[3] = 1'b0;
        #1;
        check("R9", "pair3 masked", 32'(link_irq), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule